// File: doc/BRIEF.md
# Transmit Modulation Mode Controller

This block turns one serial transmit bit per symbol into the settings that drive a radio transmitter: a divide word for a fractional-N synthesizer (an integer part and a 12-bit fractional part) and a 7-bit level code with an enable for the power-amplifier DAC. A 2-bit mode input selects how the bit is used. In the frequency-keyed modes the bit moves the synthesizer word above or below a programmed centre. In the amplitude-keyed modes the bit picks one of two power codes, or switches the stage off.

All inputs are sampled into a register stage on every clock. The output registers load only when the registered symbol strobe is high. A strobe presented with its data therefore appears at the outputs after the second rising clock edge. The sigma-delta modulator, the loop, the oscillator, any Gaussian shaping and the analog stage are all outside this block.

Top module: `tx_mod_ctrl`

## Requirements
- R1: While rst_ni is low, and after its release until the first strobe, int_word_o, frac_word_o and pa_code_o are zero and pa_en_o is 0.
- R2: The outputs change only after a strobe. Inputs that are presented together with sym_stb_i=1 before rising edge k appear at the outputs after rising edge k+1. Input changes made while no strobe is given have no effect on any output.
- R3: In frequency keying (mode_i=2'b00), tx_bit_i=1 gives {int_word_o,frac_word_o} = {int_div_i,frac_div_i} + dev_i.
- R4: In frequency keying, tx_bit_i=0 gives {int_word_o,frac_word_o} = {int_div_i,frac_div_i} - dev_i.
- R5: A carry out of the 12-bit fractional field increments the integer word, and a borrow decrements it. The integer word wraps modulo 2^INT_W.
- R6: In the frequency-keyed modes a dev_i of 0 is treated as 1.
- R7: mode_i=2'b01 is reserved for shaped frequency keying. It produces exactly the same outputs as mode_i=2'b00.
- R8: In both frequency-keyed modes pa_code_o = pwr_hi_i and pa_en_o = 1.
- R9: In amplitude keying (mode_i=2'b10), pa_en_o = 1. pa_code_o is dev_i when the bit is 0 and pwr_hi_i when the bit is 1. The divide word equals the unmodified centre.
- R10: In on-off keying (mode_i=2'b11), bit 1 gives pa_code_o = pwr_hi_i with pa_en_o = 1. Bit 0 gives pa_code_o = 0 with pa_en_o = 0. The divide word equals the centre.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_stb_i | input | 1 | Symbol strobe; loads outputs |
| tx_bit_i | input | 1 | Transmit data bit |
| mode_i | input | 2 | 00 FSK, 01 shaped FSK, 10 ASK, 11 OOK |
| dev_i | input | 7 | Deviation number, or the low power code in ASK |
| pwr_hi_i | input | 7 | High power code |
| int_div_i | input | INT_W | Integer part of the centre divide word |
| frac_div_i | input | 12 | Fractional part of the centre divide word |
| int_word_o | output | INT_W | Integer divide word to the modulator |
| frac_word_o | output | 12 | Fractional divide word to the modulator |
| pa_code_o | output | 7 | PA DAC level code |
| pa_en_o | output | 1 | PA enable |

## Verification
A corrupted input-stage register or output register shows up at the ports after the next strobe, which is two edges after the strobe is presented. It appears either as a divide word that is off by the deviation or by one integer step at a fractional wrap, or as the wrong power code or enable. A fault in the hold path shows up as outputs that move during a run of cycles without a strobe. The bench looks for that drift within three cycles.

// File: rtl/tx_mod_pkg.sv
package tx_mod_pkg;
  localparam int FRAC_W = 12;
  localparam int LVL_W  = 7;

  typedef enum logic [1:0] {
    MODE_FSK  = 2'b00,
    MODE_GFSK = 2'b01,
    MODE_ASK  = 2'b10,
    MODE_OOK  = 2'b11
  } mode_e;
endpackage

// File: rtl/tx_mod_in_reg.sv
module tx_mod_in_reg
  import tx_mod_pkg::*;
#(
  parameter int INT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic              bit_i,
  input  logic [1:0]        mode_i,
  input  logic [LVL_W-1:0]  dev_i,
  input  logic [LVL_W-1:0]  pwr_i,
  input  logic [INT_W-1:0]  int_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              stb_o,
  output logic              bit_o,
  output mode_e             mode_o,
  output logic [LVL_W-1:0]  dev_o,
  output logic [LVL_W-1:0]  pwr_o,
  output logic [INT_W-1:0]  int_o,
  output logic [FRAC_W-1:0] frac_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_o  <= 1'b0;
      bit_o  <= 1'b0;
      mode_o <= MODE_FSK;
      dev_o  <= '0;
      pwr_o  <= '0;
      int_o  <= '0;
      frac_o <= '0;
    end else begin
      stb_o  <= stb_i;
      bit_o  <= bit_i;
      mode_o <= mode_e'(mode_i);
      dev_o  <= dev_i;
      pwr_o  <= pwr_i;
      int_o  <= int_i;
      frac_o <= frac_i;
    end
  end
endmodule

// File: rtl/tx_mod_freq.sv
module tx_mod_freq
  import tx_mod_pkg::*;
#(
  parameter int INT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fsk_i,
  input  logic              bit_i,
  input  logic [LVL_W-1:0]  dev_i,
  input  logic [INT_W-1:0]  int_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic [INT_W-1:0]  int_o,
  output logic [FRAC_W-1:0] frac_o
);
  localparam int W = INT_W + FRAC_W;

  logic [LVL_W-1:0] dev_eff;
  logic [W-1:0]     center, step, word;

  // zero deviation is illegal; clamp to one step
  assign dev_eff = (dev_i == '0) ? LVL_W'(1) : dev_i;
  assign center  = {int_i, frac_i};
  assign step    = W'(dev_eff);

  always_comb begin
    if (!fsk_i)     word = center;
    else if (bit_i) word = center + step;
    else            word = center - step;
  end

  assign {int_o, frac_o} = word;

  AST_FSK_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsk_i |-> ({int_o, frac_o} != center)) else $error("fsk word equals centre"); // R6
  AST_KEYED_CENTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fsk_i |-> (int_o == int_i && frac_o == frac_i)) else $error("word moved outside fsk"); // R9
endmodule

// File: rtl/tx_mod_pa.sv
module tx_mod_pa
  import tx_mod_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  mode_e            mode_i,
  input  logic             bit_i,
  input  logic [LVL_W-1:0] lo_i,
  input  logic [LVL_W-1:0] hi_i,
  output logic [LVL_W-1:0] code_o,
  output logic             en_o
);
  always_comb begin
    unique case (mode_i)
      MODE_ASK: begin
        code_o = bit_i ? hi_i : lo_i;
        en_o   = 1'b1;
      end
      MODE_OOK: begin
        code_o = bit_i ? hi_i : '0;
        en_o   = bit_i;
      end
      default: begin
        code_o = hi_i;
        en_o   = 1'b1;
      end
    endcase
  end

  AST_OOK_OFF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_o |-> (code_o == '0 && mode_i == MODE_OOK)) else $error("pa off with code"); // R10
endmodule

// File: rtl/tx_mod_ctrl.sv
module tx_mod_ctrl
  import tx_mod_pkg::*;
#(
  parameter int INT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sym_stb_i,
  input  logic              tx_bit_i,
  input  logic [1:0]        mode_i,
  input  logic [6:0]        dev_i,
  input  logic [6:0]        pwr_hi_i,
  input  logic [INT_W-1:0]  int_div_i,
  input  logic [11:0]       frac_div_i,
  output logic [INT_W-1:0]  int_word_o,
  output logic [11:0]       frac_word_o,
  output logic [6:0]        pa_code_o,
  output logic              pa_en_o
);
  logic              stb_q, bit_q;
  mode_e             mode_q;
  logic [LVL_W-1:0]  dev_q, pwr_q, code_d;
  logic [INT_W-1:0]  int_q, int_d;
  logic [FRAC_W-1:0] frac_q, frac_d;
  logic              en_d, fsk_q;

  tx_mod_in_reg #(.INT_W(INT_W)) u_in (
    .clk_i, .rst_ni,
    .stb_i(sym_stb_i), .bit_i(tx_bit_i), .mode_i,
    .dev_i, .pwr_i(pwr_hi_i), .int_i(int_div_i), .frac_i(frac_div_i),
    .stb_o(stb_q), .bit_o(bit_q), .mode_o(mode_q),
    .dev_o(dev_q), .pwr_o(pwr_q), .int_o(int_q), .frac_o(frac_q)
  );

  assign fsk_q = (mode_q == MODE_FSK) || (mode_q == MODE_GFSK);

  tx_mod_freq #(.INT_W(INT_W)) u_freq (
    .clk_i, .rst_ni,
    .fsk_i(fsk_q), .bit_i(bit_q), .dev_i(dev_q),
    .int_i(int_q), .frac_i(frac_q),
    .int_o(int_d), .frac_o(frac_d)
  );

  tx_mod_pa u_pa (
    .clk_i, .rst_ni,
    .mode_i(mode_q), .bit_i(bit_q), .lo_i(dev_q), .hi_i(pwr_q),
    .code_o(code_d), .en_o(en_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_word_o  <= '0;
      frac_word_o <= '0;
      pa_code_o   <= '0;
      pa_en_o     <= 1'b0;
    end else if (stb_q) begin
      int_word_o  <= int_d;
      frac_word_o <= frac_d;
      pa_code_o   <= code_d;
      pa_en_o     <= en_d;
    end
  end

  AST_HOLD_NO_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_q |=> ($stable(int_word_o) && $stable(frac_word_o) && $stable(pa_code_o) && $stable(pa_en_o)))
    else $error("output moved without strobe"); // R2
  AST_FSK_PA_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_q && fsk_q) |=> (pa_en_o && pa_code_o == $past(pwr_q))) else $error("fsk pa level"); // R8
  AST_ASK_CENTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_q && mode_q == MODE_ASK) |=> (pa_en_o && int_word_o == $past(int_q) && frac_word_o == $past(frac_q)))
    else $error("ask word moved"); // R9
  AST_OOK_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_q && mode_q == MODE_OOK && bit_q) |=> (pa_en_o && pa_code_o == $past(pwr_q)))
    else $error("ook mark level"); // R10
endmodule

// File: tb/tx_mod_ctrl_bench.sv
module tx_mod_ctrl_bench;
  localparam int INT_W = 8;
  localparam int W = INT_W + 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic stb = 1'b0, tbit = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [6:0] dev = '0, pwr = '0;
  logic [INT_W-1:0] idiv = '0;
  logic [11:0] fdiv = '0;
  logic [INT_W-1:0] int_o;
  logic [11:0] frac_o;
  logic [6:0] code_o;
  logic en_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tx_mod_ctrl #(.INT_W(INT_W)) u_tx_mod_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sym_stb_i(stb), .tx_bit_i(tbit), .mode_i(mode),
    .dev_i(dev), .pwr_hi_i(pwr), .int_div_i(idiv), .frac_div_i(fdiv),
    .int_word_o(int_o), .frac_word_o(frac_o), .pa_code_o(code_o), .pa_en_o(en_o)
  );

  function automatic logic [W-1:0] exp_word(logic [1:0] m, logic b, logic [6:0] d,
                                            logic [INT_W-1:0] i, logic [11:0] f);
    logic [W-1:0] c, s;
    c = {i, f};
    s = W'((d == 0) ? 7'd1 : d);
    if (m[1]) return c;
    return b ? c + s : c - s;
  endfunction

  function automatic logic [7:0] exp_pa(logic [1:0] m, logic b, logic [6:0] d, logic [6:0] p);
    case (m)
      2'b10:   return {1'b1, b ? p : d};
      2'b11:   return b ? {1'b1, p} : 8'h00;
      default: return {1'b1, p};
    endcase
  endfunction

  task automatic chk(string req, logic [W+7:0] act, logic [W+7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_of(logic [1:0] m, logic b);
    case (m)
      2'b00:   return b ? "R3" : "R4";
      2'b01:   return "R7";
      2'b10:   return "R9";
      default: return "R10";
    endcase
  endfunction

  // present one symbol, check it two edges later
  task automatic sym(logic [1:0] m, logic b, logic [6:0] d, logic [6:0] p,
                     logic [INT_W-1:0] i, logic [11:0] f, string req);
    @(negedge clk);
    mode = m; tbit = b; dev = d; pwr = p; idiv = i; fdiv = f; stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
    @(negedge clk);
    chk(req, {int_o, frac_o, en_o, code_o}, {exp_word(m, b, d, i, f), exp_pa(m, b, d, p)});
  endtask

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    chk("R1", {int_o, frac_o, en_o, code_o}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    mode = 2'b10; tbit = 1; pwr = 7'h55; idiv = 8'h12;
    repeat (3) @(negedge clk);
    chk("R1", {int_o, frac_o, en_o, code_o}, '0);

    sym(2'b00, 1, 7'd5,   7'h40, 8'h20, 12'h100, "R3");
    sym(2'b00, 0, 7'd5,   7'h40, 8'h20, 12'h100, "R4");
    sym(2'b00, 1, 7'd127, 7'h11, 8'h20, 12'hFF0, "R5");
    sym(2'b00, 0, 7'd16,  7'h11, 8'h20, 12'h008, "R5");
    sym(2'b00, 1, 7'd1,   7'h11, 8'hFF, 12'hFFF, "R5");
    sym(2'b00, 1, 7'd0,   7'h22, 8'h30, 12'h400, "R6");
    sym(2'b00, 0, 7'd0,   7'h22, 8'h30, 12'h000, "R6");
    sym(2'b01, 1, 7'd9,   7'h33, 8'h44, 12'h555, "R7");
    sym(2'b01, 0, 7'd0,   7'h33, 8'h44, 12'h555, "R7");
    sym(2'b00, 0, 7'd3,   7'h7F, 8'h01, 12'h123, "R8");
    sym(2'b10, 0, 7'h0A,  7'h70, 8'h55, 12'hABC, "R9");
    sym(2'b10, 1, 7'h0A,  7'h70, 8'h55, 12'hABC, "R9");
    sym(2'b11, 1, 7'h0A,  7'h6E, 8'h66, 12'h321, "R10");
    sym(2'b11, 0, 7'h0A,  7'h6E, 8'h66, 12'h321, "R10");

    // R2: inputs move without a strobe; outputs must hold
    sym(2'b00, 1, 7'd7, 7'h15, 8'h10, 12'h200, "R2");
    @(negedge clk);
    mode = 2'b11; tbit = 0; dev = 7'd99; pwr = 7'h01; idiv = 8'hEE; fdiv = 12'h777;
    repeat (3) @(negedge clk);
    chk("R2", {int_o, frac_o, en_o, code_o},
        {exp_word(2'b00, 1, 7'd7, 8'h10, 12'h200), exp_pa(2'b00, 1, 7'd7, 7'h15)});

    for (int n = 0; n < 400; n++) begin
      logic [1:0] m;
      logic b;
      m = 2'($urandom);
      b = 1'($urandom);
      sym(m, b, 7'($urandom), 7'($urandom), INT_W'($urandom), 12'($urandom), tag_of(m, b));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule